// File: doc/BRIEF.md
# Serial Control Port with Register Bank

This block is a 4-wire serial control slave that owns a bank of 8-bit configuration registers for a radio receiver. A host lowers the active-low chip select and toggles the serial clock. The first byte it shifts in is a command: a read flag and a 7-bit register address. One or more data bytes follow. Each data byte is either written into the register the pointer selects or read back from it. The pointer then steps forward and wraps to zero after the last register, so a long burst walks the whole bank.

The serial pins are brought into a system clock that runs at least four times faster than the serial clock. The host samples the data output on rising serial clock edges, and the block changes that output on falling edges. A mode register holds two control bits. One turns on an echo mode, in which the data output repeats the bits the host sends. The other triggers a soft reset that restores every register to its default. The last register carries a path-select bit, which is ANDed with an external pin to choose between two RF inputs. All registers are also brought out as one parallel bus.

Top module: `ctl_spi_regfile`

## Requirements
- R1: After `rst_ni` is released, registers 0x00 to 0x15 read 0x80, register 0x16 reads 0x00, register 0x17 reads 0x01, and `sdo_en_o` is 0.
- R2: A burst sends bytes MSB first, with SDI sampled on rising SCK edges. Bit 7 of the command byte is the read flag (1 = read) and bits 6:0 are the address. In a write burst, the first data byte is loaded into the addressed register at the falling SCK edge that ends the 16th bit.
- R3: A burst whose chip select rises before the 16th falling SCK edge changes no register.
- R4: In a write burst, each further data byte goes to the next address. The address after 0x17 is 0x00.
- R5: In a read burst, the data output carries the addressed register MSB first. It changes on falling edges, starting at the falling edge that ends the command byte. Later bytes read the following addresses, with the same wrap from 0x17 to 0x00.
- R6: `sdo_en_o` is 0 whenever `csn_i` is high. With echo mode off, it is 0 for a whole write burst and for the command byte of a read burst, and 1 from the end of the command byte of a read burst until chip select rises.
- R7: Echo mode is bit 1 of register 0x16. When it is 1, `sdo_en_o` goes to 1 at the first falling SCK edge of a burst. After each falling edge, SDO carries the SDI bit sampled on the rising edge just before it. A write burst is echoed in full. A read burst echoes command bits 1 to 7, and read data replaces the echo from the 8th falling edge onward.
- R8: A write to register 0x16 with bit 3 set returns every register to its R1 default and stores nothing else, so register 0x16 then reads 0x00.
- R9: `path_sel_o` equals bit 0 of register 0x17 ANDed with `path_pin_i` (1 selects input A, 0 selects input B).
- R10: When the command address is above 0x17, the burst writes nothing and every data byte read back is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 4x the SCK rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| csn_i | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data from host |
| path_pin_i | input | 1 | External pin ANDed into path select |
| sdo_o | output | 1 | Serial data to host |
| sdo_en_o | output | 1 | Output enable for SDO (0 = high impedance) |
| path_sel_o | output | 1 | RF path select, 1 = input A |
| regs_o | output | N_REGS*8 | All registers, register i at bits i*8+7:i*8 |

## Verification
A wrong pointer or bit count inside the block shows on `regs_o` at the falling edge of the 16th bit. The wrong byte lands in the wrong register, or in none, and it stays visible on the parallel bus. Read-side state errors appear on SDO by the first sampled bit of the affected byte. A stale echo flag or an enable that fails to drop shows on `sdo_en_o` within one serial bit of the cause. A soft reset that does not reach every register leaves a non-default value on `regs_o` on the next system clock.

// File: rtl/ctl_spi_pkg.sv
package ctl_spi_pkg;
  localparam int DATA_W     = 8;
  localparam int ADDR_W     = 7;
  localparam int ECHO_BIT   = 1;
  localparam int SRST_BIT   = 3;
  localparam int PATH_BIT   = 0;

  // mode register is second to last, path register is last
  function automatic logic [DATA_W-1:0] reg_reset_val(input int idx, input int n_regs);
    if (idx == n_regs - 1) return 8'h01;
    if (idx == n_regs - 2) return 8'h00;
    return 8'h80;
  endfunction
endpackage

// File: rtl/ctl_spi_sync.sv
module ctl_spi_sync #(
  parameter int              W      = 3,
  parameter int              STAGES = 2,
  parameter logic [W-1:0]    RST_V  = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= RST_V;
    end else begin
      stg[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/ctl_spi_frame.sv
module ctl_spi_frame
  import ctl_spi_pkg::*;
#(
  parameter int N_REGS = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_act_i,
  input  logic              sck_s_i,
  input  logic              sdi_s_i,
  input  logic              echo_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              sdo_o,
  output logic              sdo_en_o
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(N_REGS - 1);

  logic              sck_prev, rise, fall;
  logic [2:0]        bit_cnt;
  logic              byte_end, in_cmd, rw_rd, addr_ok;
  logic [ADDR_W-1:0] ptr, nxt;
  logic [DATA_W-1:0] shin, tx, rd_val;
  logic              cmd_ok, sdo_q, en_q;

  assign rise   = cs_act_i &  sck_s_i & ~sck_prev;
  assign fall   = cs_act_i & ~sck_s_i &  sck_prev;
  assign cmd_ok = shin[ADDR_W-1:0] <= LAST;
  assign nxt    = (ptr == LAST) ? '0 : ptr + ADDR_W'(1);

  assign rd_addr_o = in_cmd ? shin[ADDR_W-1:0] : nxt;
  assign rd_val    = (in_cmd ? cmd_ok : addr_ok) ? rd_data_i : '0;

  assign wr_en_o   = fall & byte_end & ~in_cmd & ~rw_rd & addr_ok;
  assign wr_addr_o = ptr;
  assign wr_data_o = shin;
  assign sdo_o     = sdo_q;
  assign sdo_en_o  = en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_prev <= 1'b0;
      bit_cnt  <= '0;
      byte_end <= 1'b0;
      in_cmd   <= 1'b1;
      rw_rd    <= 1'b0;
      addr_ok  <= 1'b0;
      ptr      <= '0;
      shin     <= '0;
      tx       <= '0;
      sdo_q    <= 1'b0;
      en_q     <= 1'b0;
    end else begin
      sck_prev <= sck_s_i;
      if (!cs_act_i) begin
        bit_cnt  <= '0;
        byte_end <= 1'b0;
        in_cmd   <= 1'b1;
        rw_rd    <= 1'b0;
        addr_ok  <= 1'b0;
        en_q     <= 1'b0;
      end else if (rise) begin
        shin     <= {shin[DATA_W-2:0], sdi_s_i};
        bit_cnt  <= bit_cnt + 3'd1;
        byte_end <= (bit_cnt == 3'd7);
      end else if (fall) begin
        byte_end <= 1'b0;
        if (byte_end && in_cmd) begin
          in_cmd  <= 1'b0;
          rw_rd   <= shin[DATA_W-1];
          addr_ok <= cmd_ok;
          ptr     <= shin[ADDR_W-1:0];
          if (shin[DATA_W-1]) begin
            tx    <= rd_val;
            sdo_q <= rd_val[DATA_W-1];
            en_q  <= 1'b1;
          end else begin
            sdo_q <= shin[0];
            en_q  <= echo_i;
          end
        end else if (byte_end) begin
          ptr <= nxt;
          if (rw_rd) begin
            tx    <= rd_val;
            sdo_q <= rd_val[DATA_W-1];
          end else begin
            sdo_q <= shin[0];
          end
          en_q <= echo_i | rw_rd;
        end else begin
          if (rw_rd) begin
            tx    <= {tx[DATA_W-2:0], 1'b0};
            sdo_q <= tx[DATA_W-2];
          end else begin
            sdo_q <= shin[0];
          end
          en_q <= echo_i | rw_rd;
        end
      end
    end
  end

  // R2: commits only land on a byte boundary
  p_commit_slot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (bit_cnt == 3'd0));

  // R4: pointer stays inside the bank while a valid burst runs
  p_ptr_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_ok |-> (ptr <= LAST));

  // R5: read bursts keep SDO driven after the command byte
  p_rd_drive_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_act_i && rw_rd) |-> en_q);

  // R6: a released chip select turns the driver off on the next clock
  p_release_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_act_i |=> !en_q);
endmodule

// File: rtl/ctl_spi_regs.sv
module ctl_spi_regs
  import ctl_spi_pkg::*;
#(
  parameter int N_REGS = 24
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [ADDR_W-1:0]        wr_addr_i,
  input  logic [DATA_W-1:0]        wr_data_i,
  input  logic [ADDR_W-1:0]        rd_addr_i,
  output logic [DATA_W-1:0]        rd_data_o,
  output logic [N_REGS*DATA_W-1:0] regs_o,
  output logic                     echo_o,
  output logic                     path_bit_o
);
  localparam int                IW       = $clog2(N_REGS);
  localparam int                MODE_IDX = N_REGS - 2;
  localparam int                PATH_IDX = N_REGS - 1;
  localparam logic [ADDR_W-1:0] LAST     = ADDR_W'(N_REGS - 1);
  localparam logic [ADDR_W-1:0] MODE_A   = ADDR_W'(MODE_IDX);

  logic [DATA_W-1:0] regs [N_REGS];
  logic              srst;

  assign srst = wr_en_i && (wr_addr_i == MODE_A) && wr_data_i[SRST_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_REGS; i++) regs[i] <= reg_reset_val(i, N_REGS);
    end else if (srst) begin
      for (int i = 0; i < N_REGS; i++) regs[i] <= reg_reset_val(i, N_REGS);
    end else if (wr_en_i && wr_addr_i <= LAST) begin
      regs[wr_addr_i[IW-1:0]] <= wr_data_i;
    end
  end

  assign rd_data_o  = (rd_addr_i <= LAST) ? regs[rd_addr_i[IW-1:0]] : '0;
  assign echo_o     = regs[MODE_IDX][ECHO_BIT];
  assign path_bit_o = regs[PATH_IDX][PATH_BIT];

  for (genvar g = 0; g < N_REGS; g++) begin : g_flat
    assign regs_o[g*DATA_W +: DATA_W] = regs[g];
  end

  // R2: an accepted write shows on the next clock
  p_write_lands_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !srst && wr_addr_i <= LAST) |=>
      (regs[$past(wr_addr_i[IW-1:0])] == $past(wr_data_i)));

  // R8: soft reset clears its own bit and restores the bank
  p_soft_reset_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst |=> (regs[MODE_IDX] == 8'h00 && regs[PATH_IDX] == 8'h01 && regs[0] == 8'h80));
endmodule

// File: rtl/ctl_spi_regfile.sv
module ctl_spi_regfile
  import ctl_spi_pkg::*;
#(
  parameter int N_REGS      = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     csn_i,
  input  logic                     sck_i,
  input  logic                     sdi_i,
  input  logic                     path_pin_i,
  output logic                     sdo_o,
  output logic                     sdo_en_o,
  output logic                     path_sel_o,
  output logic [N_REGS*DATA_W-1:0] regs_o
);
  logic [2:0]        pins_s;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [DATA_W-1:0] rd_data, wr_data;
  logic              wr_en, echo, path_bit, drv_en;

  ctl_spi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_V(3'b001)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sdi_i, sck_i, csn_i}),
    .q_o   (pins_s)
  );

  ctl_spi_frame #(.N_REGS(N_REGS)) u_frame (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cs_act_i (~pins_s[0]),
    .sck_s_i  (pins_s[1]),
    .sdi_s_i  (pins_s[2]),
    .echo_i   (echo),
    .rd_data_i(rd_data),
    .rd_addr_o(rd_addr),
    .wr_en_o  (wr_en),
    .wr_addr_o(wr_addr),
    .wr_data_o(wr_data),
    .sdo_o    (sdo_o),
    .sdo_en_o (drv_en)
  );

  ctl_spi_regs #(.N_REGS(N_REGS)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data),
    .regs_o    (regs_o),
    .echo_o    (echo),
    .path_bit_o(path_bit)
  );

  // raw chip select gates the driver so release is immediate
  assign sdo_en_o   = drv_en & ~csn_i;
  assign path_sel_o = path_bit & path_pin_i;
endmodule

// File: tb/tb_ctl_spi_regfile.sv
`timescale 1ns/1ps
module tb_ctl_spi_regfile;
  localparam int NR = 24;
  localparam int HB = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic csn = 1'b1, sck = 1'b0, sdi = 1'b0, pin = 1'b1;
  logic sdo, sdo_en, path_sel;
  logic [NR*8-1:0] regs;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  logic [7:0] tx_b [0:7];
  logic       samp [0:64];
  logic       samp_en [0:64];
  logic       en_after;
  logic [7:0] m [0:NR-1];

  always #2 clk = ~clk;

  ctl_spi_regfile dut (
    .clk_i(clk), .rst_ni(rst_n), .csn_i(csn), .sck_i(sck), .sdi_i(sdi),
    .path_pin_i(pin), .sdo_o(sdo), .sdo_en_o(sdo_en), .path_sel_o(path_sel),
    .regs_o(regs)
  );

  function automatic logic [7:0] dflt(input int i);
    if (i == NR - 1) return 8'h01;
    if (i == NR - 2) return 8'h00;
    return 8'h80;
  endfunction

  function automatic logic sbit(input int k);
    return tx_b[k/8][7 - (k % 8)];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wait_hb();
    repeat (HB) @(negedge clk);
  endtask

  task automatic spi_run(input int nbits, input bit drop_fall);
    csn = 1'b0;
    wait_hb();
    for (int b = 0; b < nbits; b++) begin
      sdi = sbit(b);
      wait_hb();
      samp[b] = sdo; samp_en[b] = sdo_en;
      sck = 1'b1;
      wait_hb();
      if (!(drop_fall && b == nbits - 1)) sck = 1'b0;
    end
    if (!drop_fall) begin
      wait_hb();
      samp[nbits] = sdo; samp_en[nbits] = sdo_en;
    end
    csn = 1'b1;
    #1 en_after = sdo_en;
    wait_hb();
    sck = 1'b0;
    wait_hb();
  endtask

  task automatic check_regs(input string req);
    for (int i = 0; i < NR; i++)
      chk(regs[i*8 +: 8] == m[i], req, regs[i*8 +: 8], m[i]);
  endtask

  task automatic do_write(input logic [6:0] a, input int n);
    int p;
    tx_b[0] = {1'b0, a};
    spi_run(8 * (n + 1), 1'b0);
    if (a < NR) begin
      p = a;
      for (int j = 1; j <= n; j++) begin
        if (p == NR - 2 && tx_b[j][3]) begin
          for (int i = 0; i < NR; i++) m[i] = dflt(i);
        end else begin
          m[p] = tx_b[j];
        end
        p = (p == NR - 1) ? 0 : p + 1;
      end
    end
  endtask

  task automatic do_read(input logic [6:0] a, input int n, input string req);
    int p;
    logic [7:0] got, exp;
    tx_b[0] = {1'b1, a};
    for (int j = 1; j <= n; j++) tx_b[j] = 8'($urandom);
    spi_run(8 * (n + 1), 1'b0);
    p = a;
    for (int j = 1; j <= n; j++) begin
      for (int k = 0; k < 8; k++) got[7 - k] = samp[8 * j + k];
      exp = (a < NR) ? m[p] : 8'h00;
      chk(got === exp, req, got, exp);
      p = (p == NR - 1) ? 0 : p + 1;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    bit ok;
    void'($urandom(32'h5eed));
    for (int i = 0; i < NR; i++) m[i] = dflt(i);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check_regs("R1");
    chk(sdo_en == 1'b0, "R1 sdo_en", sdo_en, 0);

    // R9 pin AND register bit
    pin = 1'b1; #1 chk(path_sel == 1'b1, "R9 pin1 bit1", path_sel, 1);
    pin = 1'b0; #1 chk(path_sel == 1'b0, "R9 pin0 bit1", path_sel, 0);
    pin = 1'b1;
    @(negedge clk);

    // R2 single write, R6 no drive during write
    tx_b[1] = 8'hA5;
    do_write(7'd5, 1);
    check_regs("R2");
    ok = 1'b1;
    for (int k = 0; k <= 16; k++) if (samp_en[k] !== 1'b0) ok = 1'b0;
    chk(ok, "R6 write burst undriven", ok, 1);
    chk(en_after == 1'b0, "R6 released", en_after, 0);

    // R3 aborted bursts
    tx_b[0] = {1'b0, 7'd6}; tx_b[1] = 8'h5A;
    spi_run(16, 1'b1);
    check_regs("R3 16 rises no fall");
    spi_run(12, 1'b0);
    check_regs("R3 12 bits");

    // R4 wrap on write
    tx_b[1] = 8'h11; tx_b[2] = 8'h22; tx_b[3] = 8'h33;
    do_write(7'd23, 3);
    check_regs("R4 wrap write");
    #1 chk(path_sel == 1'b1, "R9 bit1 pin1", path_sel, 1);
    tx_b[1] = 8'h10;
    do_write(7'd23, 1);
    #1 chk(path_sel == 1'b0, "R9 bit0 pin1", path_sel, 0);

    // R5 read with wrap, R6 enable timing
    do_read(7'd22, 4, "R5 wrap read");
    ok = 1'b1;
    for (int k = 0; k < 8; k++) if (samp_en[k] !== 1'b0) ok = 1'b0;
    for (int k = 8; k <= 40; k++) if (samp_en[k] !== 1'b1) ok = 1'b0;
    chk(ok, "R6 read enable window", ok, 1);
    chk(en_after == 1'b0, "R6 released after read", en_after, 0);

    // random mix (R2 R4 R5)
    for (int it = 0; it < 40; it++) begin
      int a, n, p;
      a = int'($urandom % NR);
      n = 1 + int'($urandom % 4);
      if ($urandom % 2) begin
        p = a;
        for (int j = 1; j <= n; j++) begin
          tx_b[j] = 8'($urandom);
          if (p == NR - 2) tx_b[j] = tx_b[j] & 8'hF5;
          p = (p == NR - 1) ? 0 : p + 1;
        end
        do_write(7'(a), n);
        check_regs("R4 random write");
      end else begin
        do_read(7'(a), n, "R5 random read");
      end
    end

    // R7 echo mode
    tx_b[1] = 8'h02;
    do_write(7'd22, 1);
    tx_b[1] = 8'h3C;
    do_write(7'd3, 1);
    ok = (samp_en[0] === 1'b0);
    for (int k = 1; k <= 16; k++) if (samp[k] !== sbit(k - 1) || samp_en[k] !== 1'b1) ok = 1'b0;
    chk(ok, "R7 write echo", ok, 1);
    check_regs("R7 write in echo");
    do_read(7'd3, 1, "R7 read data in echo");
    ok = 1'b1;
    for (int k = 1; k <= 7; k++) if (samp[k] !== sbit(k - 1) || samp_en[k] !== 1'b1) ok = 1'b0;
    chk(ok, "R7 read command echo", ok, 1);
    chk(en_after == 1'b0, "R6 released in echo", en_after, 0);

    // R8 soft reset
    tx_b[1] = 8'h0A;
    do_write(7'd22, 1);
    check_regs("R8 soft reset");
    do_read(7'd22, 1, "R8 bit reads 0");

    // R10 out-of-range address
    tx_b[1] = 8'hFF; tx_b[2] = 8'hEE;
    do_write(7'h30, 2);
    check_regs("R10 write ignored");
    do_read(7'h7F, 2, "R10 read zero");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule